// File: doc/BRIEF.md
# Retirement Progress Watchdog

This block sits beside the commit stage of a checked, speculative processor core and watches whether instructions keep retiring. A down-counter is reloaded with a worst-case single-instruction latency every time an instruction commits. If it runs out with no commit, the block raises a one-cycle expiry event. In that same cycle it asks the checker to take the next instruction with both source operands and the result forced to zero, and it asks for the core to be flushed and restarted at the next PC. Expiry outranks every other checker exception.

A second counter counts expiries that follow one another with no commit in between. When that count reaches a programmable threshold, the core is declared failed. A sticky flag then stays set until an explicit clear. While the flag is set, no more restarts are requested, and each commit by the checker immediately requests the next zero-operand injection without waiting for another expiry. Fetching the instruction, flushing the pipeline and the checking datapath itself are handled elsewhere.

Top module: `retire_watchdog`

## Requirements
- R1: While rst_n is low on a clock edge, the countdown loads the parameter RESET_RELOAD (default 60) and the flag and the streak clear. After reset, with no commit, the first expiry comes after exactly RESET_RELOAD expiry-free cycles.
- R2: A commit in cycle t loads reload_i. With no further commit, expiry_o is high in cycle t+1+reload_i, and not before.
- R3: expiry_o is high exactly in the cycles where the countdown is zero and commit_i is low. When reload_i is non-zero, it is never high in two cycles in a row.
- R4: After an expiry the countdown loads reload_i, so a stalled core sees one expiry every reload_i+1 cycles. With reload_i of 0, that is one expiry every cycle.
- R5: If commit_i arrives in the cycle the countdown is zero, it counts as a commit: no expiry, no injection, no restart, and the countdown reloads.
- R6: inject_zero_o is high in every expiry cycle. While core_failed_o is set, it is also high in every cycle where commit_i is high.
- R7: restart_o is high in an expiry cycle only while core_failed_o is low, and it is low at all other times.
- R8: Each expiry adds one to a streak counter, which saturates at its maximum. Any commit clears the streak. core_failed_o rises in the cycle after the expiry that brings the streak up to limit_i. A limit_i of 0 or 1 fails on the first expiry.
- R9: core_failed_o stays set through commits and expiries until failed_clr_i is high on an edge. The clear also zeroes the streak and wins over a simultaneous set.
- R10: reload_i is only sampled when the countdown loads. Changing it mid-count does not move the pending expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| commit_i | input | 1 | One instruction retired this cycle |
| reload_i | input | CNT_W | Countdown value loaded on commit or expiry |
| limit_i | input | STRK_W | Back-to-back expiry count that declares the core failed |
| failed_clr_i | input | 1 | Clears the failed flag and the streak |
| expiry_o | output | 1 | Single-cycle lockup event |
| inject_zero_o | output | 1 | Request: next instruction enters with zero operands and result |
| restart_o | output | 1 | Request: flush the core and restart at the next PC |
| core_failed_o | output | 1 | Sticky takeover flag |

## Verification
The bench builds the block with CNT_W=6, STRK_W=3 and RESET_RELOAD=6. The short reset interval makes the first expiry after reset reachable in a handful of cycles. The 3-bit streak lets the saturation point of 7 be reached together with a limit of 7. Reload values of 0, 3, 5 and 6 cover expiry every cycle, a mid-count change of the reload value, and commits that land exactly on the zero count.

// File: rtl/rw_pkg.sv
// Package: shared constants and the request bundle for the retirement watchdog.
// Assumes: nothing beyond IEEE 1800-2017.
package rw_pkg;
    // Worst-case single-instruction latency used as the reset reload value.
    localparam int RW_DEFAULT_RELOAD = 60;

    // Requests issued toward the checker and the core.
    typedef struct packed {
        logic inject;
        logic restart;
    } rw_req_t;
endpackage

// File: rtl/rw_countdown.sv
// Module: progress countdown. Loads on commit or expiry, otherwise counts down.
// Assumes: commit_i is a one-cycle pulse per retired instruction; a commit
// in the zero-count cycle suppresses the expiry.
module rw_countdown #(
    parameter int CNT_W        = 8,
    parameter int RESET_RELOAD = rw_pkg::RW_DEFAULT_RELOAD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             expiry_o
);
    localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(RESET_RELOAD);

    logic [CNT_W-1:0] cnt_q;

    // Expiry: zero count and no commit rescuing this cycle.
    assign expiry_o = (cnt_q == '0) && !commit_i;

    // Countdown register: load on commit or expiry, else decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RST_VAL;
        end else if (commit_i || expiry_o) begin
            cnt_q <= reload_i;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R2
    reload_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (cnt_q == $past(reload_i)));

    // R4
    expiry_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expiry_o |=> (cnt_q == $past(reload_i)));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expiry_o && reload_i != '0) |=> !expiry_o);
endmodule

// File: rtl/rw_streak.sv
// Module: back-to-back expiry counter and the sticky core-failed flag.
// Assumes: expiry_i and commit_i are never high together (the countdown
// guarantees this); clr_i wins over every other update.
module rw_streak #(
    parameter int STRK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic              expiry_i,
    input  logic              clr_i,
    input  logic [STRK_W-1:0] limit_i,
    output logic              failed_o
);
    logic [STRK_W-1:0] strk_q;
    logic [STRK_W:0]   strk_next;
    logic              hit;
    logic              failed_q;

    // Streak value this expiry would produce, and whether it meets the limit.
    always_comb begin
        strk_next = {1'b0, strk_q} + 1'b1;
        hit       = expiry_i && (strk_next >= {1'b0, limit_i});
    end

    // Streak register: cleared by clear or commit, saturating count on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || commit_i) begin
            strk_q <= '0;
        end else if (expiry_i && (strk_q != '1)) begin
            strk_q <= strk_q + 1'b1;
        end
    end

    // Sticky failed flag: set on reaching the limit, cleared only explicitly.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            failed_q <= 1'b0;
        end else if (hit) begin
            failed_q <= 1'b1;
        end
    end

    assign failed_o = failed_q;

    // R8
    streak_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !clr_i) |=> (strk_q == '0));

    // R8
    failed_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(failed_q) |-> $past(expiry_i));

    // R9
    failed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (failed_q && !clr_i) |=> failed_q);
endmodule

// File: rtl/rw_request.sv
// Module: turns the expiry event and the failed state into requests.
// Assumes: expiry_i is already qualified by the commit in the same cycle.
module rw_request (
    input  logic            expiry_i,
    input  logic            commit_i,
    input  logic            failed_i,
    output rw_pkg::rw_req_t req_o
);
    // Request decode: inject on expiry or on takeover commits; restart only
    // while the core is still trusted.
    always_comb begin
        req_o.inject  = expiry_i || (failed_i && commit_i);
        req_o.restart = expiry_i && !failed_i;
    end
endmodule

// File: rtl/retire_watchdog.sv
// Module: top of the retirement progress watchdog. Times commits, signals
// lockup, and escalates to takeover after repeated lockups.
// Assumes: synchronous active-low reset held for at least one clock edge.
module retire_watchdog #(
    parameter int CNT_W        = 8,
    parameter int STRK_W       = 4,
    parameter int RESET_RELOAD = rw_pkg::RW_DEFAULT_RELOAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [CNT_W-1:0]  reload_i,
    input  logic [STRK_W-1:0] limit_i,
    input  logic              failed_clr_i,
    output logic              expiry_o,
    output logic              inject_zero_o,
    output logic              restart_o,
    output logic              core_failed_o
);
    logic            expiry;
    logic            failed;
    rw_pkg::rw_req_t req;

    rw_countdown #(.CNT_W(CNT_W), .RESET_RELOAD(RESET_RELOAD)) u_cd (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit_i),
        .reload_i (reload_i),
        .expiry_o (expiry)
    );

    rw_streak #(.STRK_W(STRK_W)) u_strk (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit_i),
        .expiry_i (expiry),
        .clr_i    (failed_clr_i),
        .limit_i  (limit_i),
        .failed_o (failed)
    );

    rw_request u_req (
        .expiry_i (expiry),
        .commit_i (commit_i),
        .failed_i (failed),
        .req_o    (req)
    );

    assign expiry_o      = expiry;
    assign inject_zero_o = req.inject;
    assign restart_o     = req.restart;
    assign core_failed_o = failed;

    // R6
    inject_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expiry_o |-> inject_zero_o);

    // R5
    commit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !core_failed_o) |-> (!inject_zero_o && !restart_o));
endmodule

// File: tb/retire_watchdog_bench.sv
// Bench: behavioural reference model stepped once per clock and compared
// against every output on every cycle.
module retire_watchdog_bench;
    localparam int CW = 6;
    localparam int SW = 3;
    localparam int RR = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          commit_r = 1'b0;
    logic [CW-1:0] reload_r = CW'(6);
    logic [SW-1:0] limit_r = SW'(7);
    logic          clr_r = 1'b0;
    logic          expiry_w, inject_w, restart_w, failed_w;

    int checks = 0;
    int fails  = 0;
    int cnt_m, strk_m;
    bit fail_m;
    bit last_exp;

    always #5 clk = ~clk;

    retire_watchdog #(.CNT_W(CW), .STRK_W(SW), .RESET_RELOAD(RR)) u_retire_watchdog (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit_i      (commit_r),
        .reload_i      (reload_r),
        .limit_i       (limit_r),
        .failed_clr_i  (clr_r),
        .expiry_o      (expiry_w),
        .inject_zero_o (inject_w),
        .restart_o     (restart_w),
        .core_failed_o (failed_w)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive, compare at mid-cycle, advance the model, cross the edge.
    task automatic step(input bit c, input bit k);
        bit e_exp, e_inj, e_rst;
        commit_r = c;
        clr_r    = k;
        #4;
        e_exp = (cnt_m == 0) && !c;
        e_inj = e_exp || (fail_m && c);
        e_rst = e_exp && !fail_m;
        chk(expiry_w == e_exp, "R3 expiry", int'(expiry_w), int'(e_exp));
        chk(inject_w == e_inj, "R6 inject", int'(inject_w), int'(e_inj));
        chk(restart_w == e_rst, "R7 restart", int'(restart_w), int'(e_rst));
        chk(failed_w == fail_m, "R9 failed", int'(failed_w), int'(fail_m));
        last_exp = expiry_w;
        if (k) fail_m = 1'b0;
        else if (e_exp && (strk_m + 1 >= int'(limit_r))) fail_m = 1'b1;
        if (k || c) strk_m = 0;
        else if (e_exp && strk_m < 7) strk_m++;
        if (c || e_exp) cnt_m = int'(reload_r);
        else cnt_m--;
        @(posedge clk);
        #1;
    endtask

    // Idle until an expiry; returns the number of quiet cycles before it.
    task automatic to_expiry(output int n);
        n = 0;
        step(1'b0, 1'b0);
        while (!last_exp && n < 100) begin
            n++;
            step(1'b0, 1'b0);
        end
    endtask

    initial begin
        int n;
        cnt_m = RR; strk_m = 0; fail_m = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(failed_w == 1'b0, "R1 reset flag", int'(failed_w), 0);
        chk(restart_w == 1'b0, "R1 reset restart", int'(restart_w), 0);
        rst_n = 1'b1;

        to_expiry(n);
        chk(n == RR, "R1 first expiry", n, RR);
        limit_r = SW'(3);
        to_expiry(n);
        chk(n == 6, "R4 repeat interval", n, 6);

        reload_r = CW'(3);
        step(1'b1, 1'b0);
        to_expiry(n);
        chk(n == 3, "R2 commit reload", n, 3);

        while (cnt_m != 0) step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        chk(last_exp == 1'b0, "R5 commit on zero", int'(last_exp), 0);

        step(1'b1, 1'b0);
        reload_r = CW'(5);
        to_expiry(n);
        chk(n == 3, "R10 mid-count reload", n, 3);
        to_expiry(n);
        chk(n == 5, "R10 new reload", n, 5);

        step(1'b1, 1'b0);
        repeat (3) to_expiry(n);
        step(1'b0, 1'b0);
        chk(failed_w == 1'b1, "R8 limit reached", int'(failed_w), 1);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
        to_expiry(n);
        chk(failed_w == 1'b1, "R9 sticky", int'(failed_w), 1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        chk(failed_w == 1'b0, "R9 clear", int'(failed_w), 0);

        limit_r = SW'(0);
        to_expiry(n);
        step(1'b0, 1'b0);
        chk(failed_w == 1'b1, "R8 zero limit", int'(failed_w), 1);
        step(1'b1, 1'b1);

        limit_r  = SW'(7);
        reload_r = CW'(0);
        step(1'b1, 1'b0);
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0);
        chk(failed_w == 1'b1, "R4 R8 saturation", int'(failed_w), 1);
        step(1'b0, 1'b1);
        reload_r = CW'(4);
        for (int i = 0; i < 12; i++) step((i % 5) == 2, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule